// File: doc/BRIEF.md
# Smart Card T=0 Command Exchange Engine

This block carries out one T=0 command exchange with a smart card over a byte-wide, half-duplex character link. A host loads a five-byte command header, a transfer direction and a data length, then pulses a start strobe. The engine sends the header. It then reads procedure bytes from the card and acts on each one: it keeps waiting, moves all remaining data, or moves a single data byte. It ends by collecting the two status bytes.

The engine sits between a character-level UART (framing, parity and guard time are handled there) and a data buffer. It gives outbound bytes to the UART through a valid/ready pair and learns from a line-idle input when the last byte has fully left. Received bytes arrive as one-cycle strobes, and the engine accepts them only while its receiver is enabled. A per-byte waiting-time budget, counted in elementary time units from an external tick, guards every byte the engine waits for. The result is reported through held status-byte, done and error outputs.

Top module: `t0x_exchange`

## Requirements
- R1: After an accepted start, the five header bytes go out in order, byte k taken from `hdr[8k+7:8k]`, before any byte is received. Byte 1 is the instruction byte (INS).
- R2: A received 0x60 is a NULL procedure byte. The engine keeps waiting for a procedure byte and reloads the waiting-time budget.
- R3: A procedure byte whose upper nibble is 0x6 or 0x9, other than 0x60, is stored as SW1. The next received byte is stored as SW2, and the exchange ends with `done`=1 and `err`=0.
- R4: A procedure byte equal to INS transfers all remaining data bytes, from the current index up to `data_len`, then the engine waits for the next procedure byte. With `wr_dir`=1 the bytes are read from `buf_rdata` at `buf_addr` and sent. With `wr_dir`=0 they are received and written with `buf_we`.
- R5: A procedure byte equal to the bitwise inverse of INS transfers exactly one data byte in the selected direction, then the engine waits for the next procedure byte.
- R6: An INS or inverted-INS byte that arrives when no data remains ends the exchange with `err`=2 (invalid). Any other procedure byte also ends it with `err`=2. The classification order is: NULL, then SW1, then INS, then inverted INS.
- R7: `rx_en` is low while the engine transmits and stays low until `tx_idle` is seen. Bytes strobed while `rx_en` is low have no effect.
- R8: While waiting for a byte, `WT_ETU` ETU ticks without a received byte end the exchange with `err`=1 (timeout). The budget reloads after every received byte.
- R9: Every accepted start produces a one-cycle `rx_flush` pulse in the cycle after the strobe.
- R10: A start with `data_len` greater than `DEPTH` sends nothing. It ends at once with `done`=1 and `err`=3 (overrun).
- R11: `done`, `err`, `sw1` and `sw2` keep their values until the next accepted start. A start strobe during a busy exchange is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an exchange (ignored while busy) |
| wr_dir | input | 1 | 1: data goes to the card, 0: data comes from the card |
| hdr | input | 40 | Command header; byte k at bits [8k+7:8k] |
| data_len | input | LEN_W | Number of data bytes in the exchange |
| buf_addr | output | LEN_W | Data buffer index |
| buf_rdata | input | 8 | Buffer byte at `buf_addr` (combinational read) |
| buf_we | output | 1 | Write strobe for a received data byte |
| buf_wdata | output | 8 | Received data byte |
| tx_valid | output | 1 | Byte offered to the UART |
| tx_byte | output | 8 | Byte to send |
| tx_ready | input | 1 | UART takes the byte this cycle |
| tx_idle | input | 1 | Transmit line empty, last byte fully sent |
| rx_en | output | 1 | Receiver enabled |
| rx_flush | output | 1 | One-cycle request to drop stale received bytes |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| etu_tick | input | 1 | One pulse per elementary time unit |
| sw1 | output | 8 | First status byte |
| sw2 | output | 8 | Second status byte |
| done | output | 1 | Exchange finished (held) |
| err | output | 2 | 0 none, 1 timeout, 2 invalid, 3 overrun (held) |

## Verification
The assertions check the following on every cycle:
- the receiver never switches on except right after the line was idle;
- the waiting-time counter never reaches zero, and an expiry always ends in a timeout result;
- data buffer writes stay below the loaded length;
- a held result survives until a new start, and a start during an exchange causes no flush.

Only the bench scenarios can show the things that depend on what the card sends back:
- the exact header order;
- the procedure-byte classification and its precedence;
- the all-remaining versus single-byte transfers in both directions, with the data landing at the right buffer indices;
- the reload of the budget on NULL bytes;
- the dropping of echo bytes.

// File: rtl/t0x_pkg.sv
package t0x_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND_HDR,
      ST_DRAIN,
      ST_WAIT_PB,
      ST_XFER_TX,
      ST_XFER_RX,
      ST_WAIT_SW2
   } t0x_state_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_TIMEOUT = 2'd1,
      ERR_INVALID = 2'd2,
      ERR_OVERRUN = 2'd3
   } t0x_err_e;

   typedef enum logic [2:0] {
      PB_NULL,
      PB_SW1,
      PB_ALL,
      PB_ONE,
      PB_BAD
   } t0x_pb_e;

   localparam int unsigned HDR_BYTES = 5;
   localparam logic [7:0]  NULL_BYTE = 8'h60;

endpackage

// File: rtl/t0x_pb_class.sv
module t0x_pb_class
   import t0x_pkg::*;
(
   input  logic [7:0] pb,
   input  logic [7:0] ins,
   output t0x_pb_e    kind
);

   always_comb begin
      if (pb == NULL_BYTE)
         kind = PB_NULL;
      else if (pb[7:4] == 4'h6 || pb[7:4] == 4'h9)
         kind = PB_SW1;
      else if (pb == ins)
         kind = PB_ALL;
      else if (pb == ~ins)
         kind = PB_ONE;
      else
         kind = PB_BAD;
   end

endmodule

// File: rtl/t0x_wait_timer.sv
module t0x_wait_timer #(
   parameter int unsigned WT_ETU = 9600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic got_byte,
   input  logic etu_tick,
   output logic expire
);

   localparam int unsigned CW = $clog2(WT_ETU + 1);

   logic [CW-1:0] cnt_q;

   assign expire = arm && etu_tick && !got_byte && (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CW'(WT_ETU);
      else if (!arm || got_byte)
         cnt_q <= CW'(WT_ETU);
      else if (etu_tick && cnt_q != CW'(1))
         cnt_q <= cnt_q - CW'(1);
   end

   // R8: the budget counter never runs down to zero
   p_wt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) && (cnt_q <= CW'(WT_ETU)));

endmodule

// File: rtl/t0x_exchange.sv
module t0x_exchange
   import t0x_pkg::*;
#(
   parameter int unsigned LEN_W  = 9,
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned WT_ETU = 9600
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             wr_dir,
   input  logic [39:0]      hdr,
   input  logic [LEN_W-1:0] data_len,
   output logic [LEN_W-1:0] buf_addr,
   input  logic [7:0]       buf_rdata,
   output logic             buf_we,
   output logic [7:0]       buf_wdata,
   output logic             tx_valid,
   output logic [7:0]       tx_byte,
   input  logic             tx_ready,
   input  logic             tx_idle,
   output logic             rx_en,
   output logic             rx_flush,
   input  logic             rx_valid,
   input  logic [7:0]       rx_byte,
   input  logic             etu_tick,
   output logic [7:0]       sw1,
   output logic [7:0]       sw2,
   output logic             done,
   output logic [1:0]       err
);

   localparam int unsigned HW = $clog2(HDR_BYTES);
   localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);

   generate
      if (LEN_W < 1 || DEPTH < 1 || DEPTH >= (1 << LEN_W)) begin : g_bad_depth
         $error("t0x_exchange: DEPTH must be 1..2**LEN_W-1");
      end
      if (WT_ETU < 2) begin : g_bad_wt
         $error("t0x_exchange: WT_ETU must be at least 2");
      end
   endgenerate

   t0x_state_e       state_q;
   logic [39:0]      hdr_q;
   logic             wr_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] idx_q;
   logic [LEN_W-1:0] end_q;
   logic [HW-1:0]    hcnt_q;
   logic [7:0]       sw1_q, sw2_q;
   logic             done_q, flush_q;
   t0x_err_e         err_q;

   logic [7:0] hdr_b [HDR_BYTES];
   for (genvar k = 0; k < HDR_BYTES; k++) begin : g_hdr_bytes
      assign hdr_b[k] = hdr_q[8*k +: 8];
   end

   logic       busy, listening, expire;
   t0x_pb_e    pb_kind;
   logic [LEN_W-1:0] idx_next;

   assign busy      = (state_q != ST_IDLE);
   assign listening = (state_q == ST_WAIT_PB) || (state_q == ST_XFER_RX) ||
                      (state_q == ST_WAIT_SW2);
   assign idx_next  = idx_q + LEN_W'(1);

   t0x_pb_class i_class (
      .pb   (rx_byte),
      .ins  (hdr_b[1]),
      .kind (pb_kind)
   );

   t0x_wait_timer #(.WT_ETU(WT_ETU)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (listening),
      .got_byte (rx_valid),
      .etu_tick (etu_tick),
      .expire   (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hdr_q   <= '0;
         wr_q    <= 1'b0;
         len_q   <= '0;
         idx_q   <= '0;
         end_q   <= '0;
         hcnt_q  <= '0;
         sw1_q   <= '0;
         sw2_q   <= '0;
         done_q  <= 1'b0;
         flush_q <= 1'b0;
         err_q   <= ERR_NONE;
      end else begin
         flush_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               flush_q <= 1'b1;
               hdr_q   <= hdr;
               wr_q    <= wr_dir;
               len_q   <= data_len;
               idx_q   <= '0;
               hcnt_q  <= '0;
               sw1_q   <= '0;
               sw2_q   <= '0;
               if (data_len > DEPTH_L) begin
                  done_q <= 1'b1;
                  err_q  <= ERR_OVERRUN;
               end else begin
                  done_q  <= 1'b0;
                  err_q   <= ERR_NONE;
                  state_q <= ST_SEND_HDR;
               end
            end
            ST_SEND_HDR: if (tx_ready) begin
               if (hcnt_q == HW'(HDR_BYTES - 1))
                  state_q <= ST_DRAIN;
               else
                  hcnt_q <= hcnt_q + HW'(1);
            end
            ST_DRAIN: if (tx_idle) state_q <= ST_WAIT_PB;
            ST_WAIT_PB: begin
               if (expire) begin
                  state_q <= ST_IDLE; done_q <= 1'b1; err_q <= ERR_TIMEOUT;
               end else if (rx_valid) begin
                  unique case (pb_kind)
                     PB_NULL: ;
                     PB_SW1: begin
                        sw1_q   <= rx_byte;
                        state_q <= ST_WAIT_SW2;
                     end
                     PB_ALL, PB_ONE: begin
                        if (idx_q >= len_q) begin
                           state_q <= ST_IDLE; done_q <= 1'b1; err_q <= ERR_INVALID;
                        end else begin
                           end_q   <= (pb_kind == PB_ALL) ? len_q : idx_next;
                           state_q <= wr_q ? ST_XFER_TX : ST_XFER_RX;
                        end
                     end
                     default: begin
                        state_q <= ST_IDLE; done_q <= 1'b1; err_q <= ERR_INVALID;
                     end
                  endcase
               end
            end
            ST_XFER_TX: if (tx_ready) begin
               idx_q <= idx_next;
               if (idx_next == end_q) state_q <= ST_DRAIN;
            end
            ST_XFER_RX: begin
               if (expire) begin
                  state_q <= ST_IDLE; done_q <= 1'b1; err_q <= ERR_TIMEOUT;
               end else if (rx_valid) begin
                  idx_q <= idx_next;
                  if (idx_next == end_q) state_q <= ST_WAIT_PB;
               end
            end
            ST_WAIT_SW2: begin
               if (expire) begin
                  state_q <= ST_IDLE; done_q <= 1'b1; err_q <= ERR_TIMEOUT;
               end else if (rx_valid) begin
                  sw2_q   <= rx_byte;
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  err_q   <= ERR_NONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign tx_valid  = (state_q == ST_SEND_HDR) || (state_q == ST_XFER_TX);
   assign tx_byte   = (state_q == ST_SEND_HDR) ? hdr_b[hcnt_q] : buf_rdata;
   assign buf_addr  = idx_q;
   assign buf_we    = (state_q == ST_XFER_RX) && rx_valid;
   assign buf_wdata = rx_byte;
   assign rx_en     = listening;
   assign rx_flush  = flush_q;
   assign sw1       = sw1_q;
   assign sw2       = sw2_q;
   assign done      = done_q;
   assign err       = err_q;

   // R7: the receiver switches on only after the line was seen idle
   p_rx_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_en) |-> $past(tx_idle));

   // R7: never listening while offering a byte
   p_no_listen_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !rx_en);

   // R4: received data stays inside the loaded length
   p_buf_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (buf_addr < len_q));

   // R8: an expiry always ends in a timeout result
   p_expire_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (done && err == 2'd1));

   // R11: a finished result is held until the next start
   p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(err) && $stable(sw2)));

   // R11: a start during an exchange causes no flush
   p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !rx_flush);

   // R9: a flush pulse only follows a start strobe
   p_flush_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |-> $past(start));

endmodule

// File: tb/test_t0x_exchange.sv
`timescale 1ns/1ps
module test_t0x_exchange;

   localparam int LEN_W = 8;
   localparam int DEPTH = 16;
   localparam int WT    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, wr_dir = 1'b0;
   logic [39:0] hdr = '0;
   logic [LEN_W-1:0] data_len = '0;
   logic [LEN_W-1:0] buf_addr;
   logic [7:0] buf_rdata, buf_wdata, tx_byte, sw1, sw2;
   logic buf_we, tx_valid, rx_en, rx_flush, done;
   logic tx_ready = 1'b1;
   logic tx_idle;
   logic rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic etu_tick = 1'b0;
   logic [1:0] err;

   always #2.5 clk = ~clk;

   t0x_exchange #(.LEN_W(LEN_W), .DEPTH(DEPTH), .WT_ETU(WT)) i_t0x_exchange (
      .clk(clk), .rst_n(rst_n), .start(start), .wr_dir(wr_dir), .hdr(hdr),
      .data_len(data_len), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
      .buf_we(buf_we), .buf_wdata(buf_wdata), .tx_valid(tx_valid),
      .tx_byte(tx_byte), .tx_ready(tx_ready), .tx_idle(tx_idle),
      .rx_en(rx_en), .rx_flush(rx_flush), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .etu_tick(etu_tick), .sw1(sw1), .sw2(sw2),
      .done(done), .err(err));

   // Card-side models: buffer, transmitter log, line idle, ETU ticks
   logic [7:0] mem [DEPTH];
   logic [7:0] txlog [64];
   int tx_n = 0;
   int idle_cnt = 0;
   int tick_div = 0;

   assign buf_rdata = mem[buf_addr[3:0]];
   assign tx_idle   = (idle_cnt == 0);

   always @(posedge clk) begin
      if (buf_we) mem[buf_addr[3:0]] <= buf_wdata;
      if (tx_valid && tx_ready) begin
         txlog[tx_n[5:0]] <= tx_byte;
         tx_n     <= tx_n + 1;
         idle_cnt <= 3;
      end else if (idle_cnt != 0) begin
         idle_cnt <= idle_cnt - 1;
      end
   end

   always @(negedge clk) begin
      tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
      etu_tick <= (tick_div == 3);
   end

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_start(input logic [39:0] h, input logic w, input int len,
                           output logic flush_seen);
      @(negedge clk);
      hdr = h; wr_dir = w; data_len = LEN_W'(len); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      flush_seen = rx_flush;
   endtask

   task automatic send_rx(input logic [7:0] b);
      for (int g = 0; g < 300 && !rx_en; g++) @(negedge clk);
      rx_byte = b; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int g;
      for (g = 0; g < 400 && !done; g++) @(negedge clk);
      chk(req, done, 1'b1);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // vector = {procedure byte, expected err, expected sw1}; INS 0xA4, no data
   localparam int NV = 7;
   localparam logic [23:0] VEC [NV] = '{
      {8'h90, 8'd0, 8'h90},
      {8'h6C, 8'd0, 8'h6C},
      {8'h9F, 8'd0, 8'h9F},
      {8'h61, 8'd0, 8'h61},
      {8'hA4, 8'd2, 8'h00},
      {8'h5B, 8'd2, 8'h00},
      {8'h3E, 8'd2, 8'h00}
   };

   localparam logic [39:0] HDR_SEL  = {8'h02, 8'h00, 8'h00, 8'hA4, 8'hA0};
   localparam logic [39:0] HDR_RD3  = {8'h03, 8'h00, 8'h00, 8'hB0, 8'hA0};
   localparam logic [39:0] HDR_NOD  = {8'h00, 8'h00, 8'h00, 8'hA4, 8'hA0};

   initial begin : watchdog
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : main
      logic fl;
      int base;
      for (int k = 0; k < DEPTH; k++) mem[k] = 8'h00;
      idle(3);
      // reset state (R11)
      chk("R11 reset done", done, 1'b0);
      chk("R11 reset err", err, 2'd0);
      chk("R7 reset rx_en", rx_en, 1'b0);
      chk("R1 reset tx_valid", tx_valid, 1'b0);
      rst_n = 1'b1;
      idle(2);

      // table: procedure-byte classification (R1 R3 R6 R9)
      for (int v = 0; v < NV; v++) begin
         base = tx_n;
         do_start(HDR_NOD, 1'b1, 0, fl);
         chk("R9 flush pulse", fl, 1'b1);
         send_rx(VEC[v][23:16]);
         chk("R1 header count before rx", tx_n - base, 5);
         for (int k = 0; k < 5; k++)
            chk("R1 header byte", txlog[(base + k) % 64], HDR_NOD[8*k +: 8]);
         if (VEC[v][15:8] == 8'd0) send_rx(8'h10 + 8'(v));
         wait_done("R3 R6 vector done");
         chk("R3 R6 vector err", err, VEC[v][9:8]);
         chk("R3 vector sw1", sw1, VEC[v][7:0]);
         if (VEC[v][15:8] == 8'd0) chk("R3 vector sw2", sw2, 8'h10 + 8'(v));
      end
      idle(1);
      chk("R9 flush one cycle", rx_flush, 1'b0);

      // R4 write all remaining, with echo injected while sending (R7)
      mem[0] = 8'h3F; mem[1] = 8'h00;
      base = tx_n;
      do_start(HDR_SEL, 1'b1, 2, fl);
      chk("R7 rx_en low while sending", rx_en, 1'b0);
      rx_byte = 8'h90; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      send_rx(8'hA4);
      send_rx(8'h90);
      send_rx(8'h00);
      wait_done("R4 write done");
      chk("R7 echo ignored err", err, 2'd0);
      chk("R7 echo ignored tx count", tx_n - base, 7);
      chk("R4 data byte 0", txlog[(base + 5) % 64], 8'h3F);
      chk("R4 data byte 1", txlog[(base + 6) % 64], 8'h00);
      chk("R3 sw 9000", {sw1, sw2}, 16'h9000);

      // R2 R5 R4 read with NULLs, single and all-remaining
      for (int k = 0; k < DEPTH; k++) mem[k] = 8'hEE;
      do_start(HDR_RD3, 1'b0, 3, fl);
      for (int g = 0; g < 50 && !rx_en; g++) @(negedge clk);
      idle(20);
      send_rx(8'h60);
      idle(20);
      send_rx(8'h4F);
      send_rx(8'h11);
      send_rx(8'h60);
      send_rx(8'hB0);
      send_rx(8'h22);
      send_rx(8'h33);
      send_rx(8'h91);
      send_rx(8'h08);
      wait_done("R2 read done");
      chk("R2 NULL reload no timeout", err, 2'd0);
      chk("R5 single byte", mem[0], 8'h11);
      chk("R4 remaining byte 1", mem[1], 8'h22);
      chk("R4 remaining byte 2", mem[2], 8'h33);
      chk("R4 no write past length", mem[3], 8'hEE);
      chk("R3 sw 9108", {sw1, sw2}, 16'h9108);

      // R6 ACK with no data left
      do_start(HDR_RD3, 1'b0, 1, fl);
      send_rx(8'hB0);
      send_rx(8'h77);
      send_rx(8'hB0);
      wait_done("R6 exhausted done");
      chk("R6 exhausted err", err, 2'd2);
      chk("R6 data kept", mem[0], 8'h77);

      // R8 timeout
      do_start(HDR_NOD, 1'b1, 0, fl);
      wait_done("R8 timeout done");
      chk("R8 timeout err", err, 2'd1);

      // R10 overrun
      base = tx_n;
      do_start(HDR_NOD, 1'b1, DEPTH + 4, fl);
      chk("R10 overrun done", done, 1'b1);
      chk("R10 overrun err", err, 2'd3);
      idle(10);
      chk("R10 nothing sent", tx_n - base, 0);

      // R11 start while busy is ignored; result held
      base = tx_n;
      do_start(HDR_NOD, 1'b1, 0, fl);
      do_start(HDR_SEL, 1'b1, 2, fl);
      chk("R11 busy start no flush", fl, 1'b0);
      send_rx(8'h62);
      send_rx(8'h83);
      wait_done("R11 done");
      chk("R11 busy start ignored count", tx_n - base, 5);
      chk("R11 busy start ignored hdr", txlog[(base + 1) % 64], 8'hA4);
      chk("R11 err", err, 2'd0);
      send_rx(8'h55);
      idle(10);
      chk("R11 done held", done, 1'b1);
      chk("R11 sw held", {sw1, sw2}, 16'h6283);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule